// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block is a general-purpose I/O port sitting on a simple word-addressed register bus. Every line has an output latch bit and a direction bit. Software changes the latch in one of three ways: it can overwrite the whole latch, it can set chosen lines with a write-one-to-set register, or it can clear chosen lines with a write-one-to-clear register. Direction can be written in either polarity. One register marks outputs and the other marks inputs. Both update the same direction state, so each one always reads back as the complement of the other.

Pin levels enter through a two-stage synchroniser. A read of the level register returns those synchronised levels for every line, whatever its direction. A parameter can reverse the bit order, so that line n sits at bit WIDTH-1-n in every register. The pins themselves stay in line order.

Top module: `gpio_mmio_port`

## Requirements
- R1: WIDTH must be 8, 16, 32 or 64, and this is checked at elaboration. The port has WIDTH lines. Reset does four things: it clears the output latch (pin_out all 0), makes every line an input (pin_oe all 0), clears the synchroniser and sets bus_rdata to 0.
- R2: A write to offset 0 (level) loads the whole output latch. pin_out shows the new value in the cycle after the write.
- R3: A write to offset 1 (set) drives high each line whose written bit is 1. Lines whose written bit is 0 keep their latch value.
- R4: A write to offset 2 (clear) drives low each line whose written bit is 1. Lines whose written bit is 0 keep their latch value.
- R5: A write to offset 3 (output-direction) loads the direction state: bit 1 makes the line an output (pin_oe=1) and bit 0 makes it an input. A read of offset 3 returns that state.
- R6: A write to offset 4 (input-direction) loads the direction state with the inverse of the written word: bit 1 makes the line an input. A read of offset 4 always returns the bitwise inverse of a read of offset 3.
- R7: A read of offset 0 returns the pin levels after two flops. If a level is present on pin_in at clock edge k, a read whose enable is sampled at edge k+2 returns it.
- R8: A read of offset 1 returns the output latch. Offset 2 and offsets 5 to 7 read as 0. Writes to offsets 5 to 7 change neither the latch nor the direction state.
- R9: bus_rdata updates at the edge that samples bus_rd and holds its value until the next read. A read and a write in the same cycle return the state from before the write.
- R10: With MIRROR=1, line n maps to register bit WIDTH-1-n in every register, for both reads and writes. pin_in, pin_out and pin_oe stay indexed by line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | WIDTH | Write data in register bit order |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Registered read data in register bit order |
| pin_in | input | WIDTH | Asynchronous pin levels, indexed by line |
| pin_out | output | WIDTH | Output latch, indexed by line |
| pin_oe | output | WIDTH | Output enable (1 = output), indexed by line |

## Verification
Two functions can fall in the same cycle: a register read, and a write that changes the state being read. The bench raises bus_rd and bus_wr together on the same offset, for both the set register and the direction register. The returned word must equal the state from before the write, and the following read must show the updated state. Pin changes are also made while level reads are issued back to back, to judge the exact two-edge synchroniser latency against a behavioural model. A second instance built with the mirrored bit order is compared against the first on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_LEVEL = 3'd0,
      REG_SET   = 3'd1,
      REG_CLR   = 3'd2,
      REG_DOUT  = 3'd3,
      REG_DIN   = 3'd4
   } reg_sel_e;

   function automatic bit width_ok(int w);
      return (w == 8) || (w == 16) || (w == 32) || (w == 64);
   endfunction
endpackage

// File: rtl/gpio_bit_order.sv
module gpio_bit_order #(
   parameter int WIDTH  = 32,
   parameter bit MIRROR = 1'b0
) (
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (MIRROR) begin : g_mirror
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign dout[i] = din[WIDTH-1-i];
         end
      end else begin : g_straight
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_async,
   output logic [WIDTH-1:0] pin_sync
);
   localparam int LAST = STAGES - 1;

   initial begin : p_chk
      assert (STAGES >= 2) else $error("gpio_pin_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= pin_async;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign pin_sync = stage_q[LAST];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WIDTH-1:0]  wr_line,
   output logic [WIDTH-1:0]  latch_q,
   output logic [WIDTH-1:0]  dir_q
);
   logic [WIDTH-1:0] latch_d, dir_d;

   always_comb begin
      latch_d = latch_q;
      dir_d   = dir_q;
      if (wr_en) begin
         case (reg_sel_e'(wr_addr))
            REG_LEVEL: latch_d = wr_line;
            REG_SET:   latch_d = latch_q | wr_line;
            REG_CLR:   latch_d = latch_q & ~wr_line;
            REG_DOUT:  dir_d   = wr_line;
            REG_DIN:   dir_d   = ~wr_line;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
      end else begin
         latch_q <= latch_d;
         dir_q   <= dir_d;
      end
   end

   // R3: set lines go high, other lines keep their value
   a_r3_set_lines: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_SET) |=>
         ((latch_q & $past(wr_line)) == $past(wr_line)) &&
         (((latch_q ^ $past(latch_q)) & ~$past(wr_line)) == '0));

   // R4: cleared lines go low, other lines keep their value
   a_r4_clr_lines: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_CLR) |=>
         ((latch_q & $past(wr_line)) == '0) &&
         (((latch_q ^ $past(latch_q)) & ~$past(wr_line)) == '0));

   // R6: the input-direction write loads the inverse into the shared state
   a_r6_dirin_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_DIN) |=> (dir_q == ~$past(wr_line)));

   // R8: writes to unused offsets are ignored
   a_r8_unused_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr > REG_DIN) |=> ($stable(latch_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_mmio_port.sv
module gpio_mmio_port
   import gpio_port_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit MIRROR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [WIDTH-1:0]  bus_wdata,
   input  logic              bus_rd,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe
);
   localparam int SYNC_STAGES = 2;

   // R1: legal register widths only
   initial begin : p_width_chk
      assert (width_ok(WIDTH)) else $error("gpio_mmio_port: WIDTH must be 8, 16, 32 or 64");
   end

   logic [WIDTH-1:0] wr_line, latch_q, dir_q, level_sync, rd_line, rd_word;

   gpio_bit_order #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_wr_order (
      .din(bus_wdata), .dout(wr_line));

   gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .pin_sync(level_sync));

   gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
      .wr_line(wr_line), .latch_q(latch_q), .dir_q(dir_q));

   always_comb begin
      case (reg_sel_e'(bus_addr))
         REG_LEVEL: rd_line = level_sync;
         REG_SET:   rd_line = latch_q;
         REG_DOUT:  rd_line = dir_q;
         REG_DIN:   rd_line = ~dir_q;
         default:   rd_line = '0;
      endcase
   end

   gpio_bit_order #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_rd_order (
      .din(rd_line), .dout(rd_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_word;
   end

   assign pin_out = latch_q;
   assign pin_oe  = dir_q;

   // R9: read data holds between reads
   a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R8: unused offsets read as zero
   a_r8_unused_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == REG_CLR || bus_addr > REG_DIN)) |=> (bus_rdata == '0));

   // R2: a level write appears on the pins one cycle later
   a_r2_level_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_LEVEL) |=> (pin_out == $past(wr_line)));
endmodule

// File: tb/tb_gpio_mmio_port.sv
module tb_gpio_mmio_port;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic wr = 1'b0, rd = 1'b0;
   logic [W-1:0] wdata = '0, wdata_rev, pins = '0;
   logic [W-1:0] rdata, pout, poe, rdata_m, pout_m, poe_m;

   always #2 clk = ~clk;   // 250 MHz

   function automatic logic [W-1:0] rev(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W-1-i];
      return r;
   endfunction

   assign wdata_rev = rev(wdata);

   gpio_mmio_port #(.WIDTH(W), .MIRROR(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
      .bus_rd(rd), .bus_rdata(rdata), .pin_in(pins), .pin_out(pout), .pin_oe(poe));

   gpio_mmio_port #(.WIDTH(W), .MIRROR(1'b1)) dut_m (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata_rev),
      .bus_rd(rd), .bus_rdata(rdata_m), .pin_in(pins), .pin_out(pout_m), .pin_oe(poe_m));

   // behavioural reference, line order
   logic [W-1:0] m_out, m_dir, m_s1, m_s2, m_rdata;
   int total = 0, bad = 0;
   string cur_req = "R1";

   function automatic logic [W-1:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_s2;
         3'd1: return m_out;
         3'd3: return m_dir;
         3'd4: return ~m_dir;
         default: return '0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_out <= '0; m_dir <= '0; m_s1 <= '0; m_s2 <= '0; m_rdata <= '0;
      end else begin
         m_s1 <= pins;
         m_s2 <= m_s1;
         if (rd) m_rdata <= m_read(addr);
         if (wr) begin
            case (addr)
               3'd0: m_out <= wdata;
               3'd1: m_out <= m_out | wdata;
               3'd2: m_out <= m_out & ~wdata;
               3'd3: m_dir <= wdata;
               3'd4: m_dir <= ~wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   // one clock; compare at the falling edge, then return for new stimulus
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      chk("pin_out", pout, m_out);
      chk("pin_oe", poe, m_dir);
      chk("rdata", rdata, m_rdata);
      chk("mirror pin_out", pout_m, m_out);
      chk("mirror pin_oe", poe_m, m_dir);
      chk("mirror rdata", rdata_m, rev(m_rdata));
   endtask

   task automatic bus(input logic [2:0] a, input logic w, input logic r, input logic [W-1:0] d);
      addr = a; wr = w; rd = r; wdata = d;
      step();
      wr = 1'b0; rd = 1'b0;
   endtask

   task automatic read_all();
      for (int a = 0; a < 8; a++) bus(a[2:0], 1'b0, 1'b1, '0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk("reset rdata", rdata, '0);
      chk("reset pin_oe", poe, '0);
      chk("reset pin_out", pout, '0);
      rst_n = 1'b1;
      step();
      read_all();

      cur_req = "R2";
      bus(3'd0, 1'b1, 1'b0, 16'hA5C3);
      bus(3'd1, 1'b0, 1'b1, '0);
      bus(3'd0, 1'b1, 1'b0, 16'h0F0F);
      bus(3'd1, 1'b0, 1'b1, '0);

      cur_req = "R3";
      bus(3'd1, 1'b1, 1'b0, 16'h00F0);
      bus(3'd1, 1'b1, 1'b0, 16'h8001);
      bus(3'd1, 1'b0, 1'b1, '0);

      cur_req = "R4";
      bus(3'd2, 1'b1, 1'b0, 16'h0F00);
      bus(3'd2, 1'b1, 1'b0, 16'h0001);
      bus(3'd1, 1'b0, 1'b1, '0);

      cur_req = "R5";
      bus(3'd3, 1'b1, 1'b0, 16'hFF00);
      bus(3'd3, 1'b0, 1'b1, '0);
      bus(3'd4, 1'b0, 1'b1, '0);

      cur_req = "R6";
      bus(3'd4, 1'b1, 1'b0, 16'h0F0F);
      bus(3'd3, 1'b0, 1'b1, '0);
      bus(3'd4, 1'b0, 1'b1, '0);

      cur_req = "R7";
      pins = 16'h1234;
      for (int i = 0; i < 4; i++) bus(3'd0, 1'b0, 1'b1, '0);
      pins = 16'hBEEF;
      for (int i = 0; i < 4; i++) bus(3'd0, 1'b0, 1'b1, '0);
      pins = 16'h0001;
      bus(3'd0, 1'b0, 1'b1, '0);
      pins = 16'h8000;
      for (int i = 0; i < 3; i++) bus(3'd0, 1'b0, 1'b1, '0);

      cur_req = "R8";
      for (int a = 5; a < 8; a++) bus(a[2:0], 1'b1, 1'b0, 16'hFFFF);
      read_all();

      cur_req = "R9";
      bus(3'd1, 1'b0, 1'b1, '0);
      for (int i = 0; i < 3; i++) step();
      bus(3'd1, 1'b1, 1'b1, 16'h7000);
      bus(3'd1, 1'b0, 1'b1, '0);
      bus(3'd3, 1'b1, 1'b1, 16'h00FF);
      bus(3'd3, 1'b0, 1'b1, '0);
      step();

      cur_req = "R10";
      bus(3'd0, 1'b1, 1'b0, 16'h0007);
      bus(3'd3, 1'b1, 1'b0, 16'h1003);
      bus(3'd2, 1'b1, 1'b0, 16'h0002);
      pins = 16'h00C1;
      read_all();
      step();
      read_all();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule